// File: doc/BRIEF.md
# Processor Counter-Timer with User Mode

This block is a per-processor counter/timer reached through a small 32-bit register port. Word offsets are decoded from address bits 4..2. A prescaler produces one count step every `TICK_DIV` clock cycles, which gives the 500 ns step at the chosen clock rate. Every count and limit value carries its least significant step at bit 9, so bits 8..0 always read as zero.

With `user_mode_i` low, the block is a periodic limit timer. It counts up to a programmed limit, wraps to zero, sets a sticky reached flag and raises `irq_o`. With `user_mode_i` high, the same register window becomes a free-running 54-bit counter. Software reads it as an upper word and a lower word, and can start, stop and reset it. No interrupt is ever raised in this mode. A change of `user_mode_i` restarts the block cleanly: the count and the flags are cleared and the counter is left running.

Top module: `proc_ctr_timer`

## Requirements
- R1: After reset the limit is the maximum value (limit word 0x7FFFFE00), the count is zero, the reached flag and `irq_o` are low and the counter is running.
- R2: The count advances by one step (one unit at bit 9) every `TICK_DIV` cycles. Any count clear restarts the prescaler, so the first step after a clear at edge E lands at edge E+`TICK_DIV`.
- R3: In limit mode, a write to offset 0 loads the limit from data bits 30..9, clears the count and drops `irq_o`. It leaves the reached flag unchanged. Bits 31 and 8..0 of the written data are ignored.
- R4: In limit mode, a write to offset 2 loads the limit the same way but leaves the count and the prescaler phase untouched.
- R5: A written limit field of zero is stored as the maximum limit, which reads back as 0x7FFFFE00.
- R6: In limit mode, when a step would make the count equal to the limit, the count becomes zero, the reached flag is set and `irq_o` rises.
- R7: In limit mode, a read of offset 1 returns {reached, count[21:0], 9'b0}. A read of offset 0 returns {1'b0, limit, 9'b0} and clears the reached flag and `irq_o`.
- R8: In user mode, a read of offset 0 returns count bits 53..23 zero-extended, and a read of offset 1 returns {count[22:0], 9'b0}. A write to offset 0 or offset 1 clears the count and restarts the prescaler.
- R9: In user mode, bit 0 of a write to offset 3 starts (1) or stops (0) counting, and a read of offset 3 returns the running state in bit 0. `irq_o` stays low for as long as user mode is active.
- R10: A change of `user_mode_i` clears the count and the reached flag, drops `irq_o` and sets the running state.
- R11: Reads of offsets with no function in the current mode return zero, and writes to them change nothing. These are offsets 4..7 in both modes, offset 2 in user mode, and offsets 2 and 3 (for reads) and 1 and 3 (for writes) in limit mode.
- R12: A read sampled at clock edge E raises `rd_valid_o` for the following cycle, with `rd_data_o` holding the state as it was before edge E.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| user_mode_i | input | 1 | High selects the free-running counter behaviour |
| req_valid_i | input | 1 | Register access request, one per cycle |
| req_write_i | input | 1 | High for a write, low for a read |
| req_addr_i | input | 5 | Byte address; bits 4..2 select the word |
| req_wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid, one cycle after the read |
| rd_data_o | output | 32 | Read data |
| irq_o | output | 1 | Limit-reached interrupt, level |

## Verification
The assertions take for granted that requests carry known values and arrive at most one per cycle. They also assume that `user_mode_i` does not toggle in the same cycle as a write that software expects to take effect, because a mode change takes priority and suppresses that write. The stimulus changes the mode only in idle cycles and drives all requests from the falling edge. The bench computes each expected count from the number of edges since the last clear, so mode changes and writes land on edges that are known exactly. The step-spacing property is generated only when `TICK_DIV` is greater than one, and the bench uses a divide ratio of four.

// File: rtl/pct_pkg.sv
package pct_pkg;

    // position of the least significant count step inside a register word
    localparam int SUB_W = 9;
    // width of the word selector taken from address bits [OFF_W+1:2]
    localparam int OFF_W = 3;

    typedef enum logic [OFF_W-1:0] {
        SEL_HI_LIMIT = 3'd0,   // limit (limit mode) / upper count word (user mode)
        SEL_LO_COUNT = 3'd1,   // count and flag (limit mode) / lower count word (user mode)
        SEL_LIM_KEEP = 3'd2,   // limit load without clear (limit mode only)
        SEL_RUN_CTRL = 3'd3    // start/stop (user mode only)
    } word_sel_e;

    // decoded register side effects handed from the port decode to the counter
    typedef struct packed {
        logic lim_load;    // take a new limit value
        logic lim_clear;   // limit-mode write that also clears the count
        logic cnt_reset;   // user-mode word write: clear the count
        logic flag_clear;  // limit-mode limit read: clear reached flag and interrupt
        logic run_wr;      // user-mode run control write
        logic run_val;     // new run state
    } ctl_t;

endpackage

// File: rtl/pct_tick_gen.sv
module pct_tick_gen #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] pre_q;

    assign tick_o = (pre_q == PW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || restart_i || tick_o) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PW'(1);
        end
    end

    generate
        if (DIV > 1) begin : g_spacing
            // R2: steps never come back to back when the divide ratio exceeds one
            a_r2_tick_gap: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o);
            // R2: a restart never produces a step in the next cycle
            a_r2_restart_phase: assert property (@(posedge clk) disable iff (rst)
                restart_i |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/pct_reg_if.sv
module pct_reg_if
    import pct_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int LIM_W  = 22,
    parameter int CNT_W  = 54
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              user_i,
    input  logic              mode_chg_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [LIM_W-1:0]  limit_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              reached_i,
    input  logic              running_i,
    output ctl_t              ctl_o,
    output logic [LIM_W-1:0]  new_limit_o,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int LO_BITS = DATA_W - SUB_W;

    word_sel_e         sel;
    logic              wr_go;
    logic              rd_go;
    logic              rd_known;
    logic [DATA_W-1:0] rd_next;
    logic [LIM_W-1:0]  lim_field;
    logic              unused_bits;

    assign sel         = word_sel_e'(req_addr_i[OFF_W+1:2]);
    assign wr_go       = req_valid_i && req_write_i && !mode_chg_i;
    assign rd_go       = req_valid_i && !req_write_i;
    assign lim_field   = req_wdata_i[DATA_W-2:SUB_W];
    assign new_limit_o = (lim_field == '0) ? '1 : lim_field;
    assign unused_bits = ^{req_addr_i, req_wdata_i};

    // read multiplexer: meaning of each word depends on the mode
    always_comb begin
        rd_next  = '0;
        rd_known = 1'b0;
        if (!user_i) begin
            case (sel)
                SEL_HI_LIMIT: begin
                    rd_next  = {1'b0, limit_i, {SUB_W{1'b0}}};
                    rd_known = 1'b1;
                end
                SEL_LO_COUNT: begin
                    rd_next  = {reached_i, cnt_i[LIM_W-1:0], {SUB_W{1'b0}}};
                    rd_known = 1'b1;
                end
                default: ;
            endcase
        end else begin
            case (sel)
                SEL_HI_LIMIT: begin
                    rd_next  = DATA_W'(cnt_i[CNT_W-1:LO_BITS]);
                    rd_known = 1'b1;
                end
                SEL_LO_COUNT: begin
                    rd_next  = {cnt_i[LO_BITS-1:0], {SUB_W{1'b0}}};
                    rd_known = 1'b1;
                end
                SEL_RUN_CTRL: begin
                    rd_next  = DATA_W'(running_i);
                    rd_known = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // side-effect decode
    always_comb begin
        ctl_o = '0;
        if (!user_i) begin
            if (wr_go && sel == SEL_HI_LIMIT) begin
                ctl_o.lim_load  = 1'b1;
                ctl_o.lim_clear = 1'b1;
            end
            if (wr_go && sel == SEL_LIM_KEEP) begin
                ctl_o.lim_load = 1'b1;
            end
            if (rd_go && !mode_chg_i && sel == SEL_HI_LIMIT) begin
                ctl_o.flag_clear = 1'b1;
            end
        end else begin
            if (wr_go && (sel == SEL_HI_LIMIT || sel == SEL_LO_COUNT)) begin
                ctl_o.cnt_reset = 1'b1;
            end
            if (wr_go && sel == SEL_RUN_CTRL) begin
                ctl_o.run_wr  = 1'b1;
                ctl_o.run_val = req_wdata_i[0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= rd_go;
            if (rd_go) begin
                rd_data_o <= rd_next;
            end
        end
    end

    // R12: every read yields exactly one valid cycle, the next one
    a_r12_read_valid: assert property (@(posedge clk) disable iff (rst)
        rd_go |=> rd_valid_o);
    a_r12_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !rd_go |=> !rd_valid_o);
    // R11: offsets without a function in the current mode read as zero
    a_r11_unused_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_go && !rd_known) |=> (rd_data_o == '0));
    // R5: a decoded limit is never zero
    a_r5_new_limit_nonzero: assert property (@(posedge clk) disable iff (rst)
        ctl_o.lim_load |-> (new_limit_o != '0));

endmodule

// File: rtl/pct_count_core.sv
module pct_count_core
    import pct_pkg::*;
#(
    parameter int LIM_W = 22,
    parameter int CNT_W = 54
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             user_i,
    input  logic             mode_chg_i,
    input  ctl_t             ctl_i,
    input  logic [LIM_W-1:0] new_limit_i,
    output logic [CNT_W-1:0] cnt_q,
    output logic [LIM_W-1:0] limit_q,
    output logic             reached_q,
    output logic             irq_q,
    output logic             running_q,
    output logic             restart_o
);
    logic [LIM_W-1:0] low_inc;
    logic             hit;
    logic             clr_cnt;
    logic             adv;
    logic             set_evt;

    assign low_inc   = cnt_q[LIM_W-1:0] + LIM_W'(1);
    assign hit       = (low_inc == limit_q);
    assign clr_cnt   = ctl_i.lim_clear || ctl_i.cnt_reset;
    assign adv       = tick_i && running_q;
    assign set_evt   = adv && !user_i && hit && !clr_cnt;
    assign restart_o = mode_chg_i || clr_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            limit_q   <= '1;
            reached_q <= 1'b0;
            irq_q     <= 1'b0;
            running_q <= 1'b1;
        end else if (mode_chg_i) begin
            cnt_q     <= '0;
            reached_q <= 1'b0;
            irq_q     <= 1'b0;
            running_q <= 1'b1;
        end else begin
            if (ctl_i.lim_load) begin
                limit_q <= new_limit_i;
            end

            if (clr_cnt) begin
                cnt_q <= '0;
            end else if (adv) begin
                if (user_i) begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end else if (hit) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= {{(CNT_W-LIM_W){1'b0}}, low_inc};
                end
            end

            // a new limit event takes priority over a clear in the same cycle
            if (set_evt) begin
                reached_q <= 1'b1;
            end else if (ctl_i.flag_clear) begin
                reached_q <= 1'b0;
            end

            if (set_evt) begin
                irq_q <= 1'b1;
            end else if (ctl_i.flag_clear || clr_cnt) begin
                irq_q <= 1'b0;
            end

            if (ctl_i.run_wr) begin
                running_q <= ctl_i.run_val;
            end
        end
    end

    // R9: no interrupt while the free-running mode is active
    a_r9_user_silent: assert property (@(posedge clk) disable iff (rst)
        user_i |-> !irq_q);
    // R6: an interrupt only rises together with a wrapped count and the flag
    a_r6_rise_on_wrap: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> (cnt_q == '0 && reached_q));
    // R2: without a step or a clear the count holds
    a_r2_hold_between_steps: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !restart_o) |=> $stable(cnt_q));
    // R10: mode change leaves a clean running counter
    a_r10_mode_change_clean: assert property (@(posedge clk) disable iff (rst)
        mode_chg_i |=> (cnt_q == '0 && !irq_q && !reached_q && running_q));
    // R3: a clearing limit write zeroes the count and drops the interrupt
    a_r3_load_clears: assert property (@(posedge clk) disable iff (rst)
        ctl_i.lim_clear |=> (cnt_q == '0 && !irq_q));
    // R5: the stored limit is never zero
    a_r5_limit_nonzero: assert property (@(posedge clk) disable iff (rst)
        limit_q != '0);

endmodule

// File: rtl/proc_ctr_timer.sv
module proc_ctr_timer
    import pct_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 5,
    parameter int CNT_W    = 54,
    parameter int TICK_DIV = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              user_mode_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);
    localparam int LIM_W = DATA_W - 1 - SUB_W;

    logic             mode_q;
    logic             mode_chg;
    logic             tick;
    logic             restart;
    ctl_t             ctl;
    logic [LIM_W-1:0] new_limit;
    logic [CNT_W-1:0] cnt;
    logic [LIM_W-1:0] limit;
    logic             reached;
    logic             running;

    // the mode is tracked during reset as well, so leaving reset is not a change
    always_ff @(posedge clk) begin
        mode_q <= user_mode_i;
    end
    assign mode_chg = (user_mode_i != mode_q);

    pct_tick_gen #(
        .DIV (TICK_DIV)
    ) u_tick (
        .clk       (clk),
        .rst       (rst),
        .restart_i (restart),
        .tick_o    (tick)
    );

    pct_reg_if #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .LIM_W  (LIM_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .user_i      (mode_q),
        .mode_chg_i  (mode_chg),
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .req_addr_i  (req_addr_i),
        .req_wdata_i (req_wdata_i),
        .limit_i     (limit),
        .cnt_i       (cnt),
        .reached_i   (reached),
        .running_i   (running),
        .ctl_o       (ctl),
        .new_limit_o (new_limit),
        .rd_valid_o  (rd_valid_o),
        .rd_data_o   (rd_data_o)
    );

    pct_count_core #(
        .LIM_W (LIM_W),
        .CNT_W (CNT_W)
    ) u_core (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick),
        .user_i      (mode_q),
        .mode_chg_i  (mode_chg),
        .ctl_i       (ctl),
        .new_limit_i (new_limit),
        .cnt_q       (cnt),
        .limit_q     (limit),
        .reached_q   (reached),
        .irq_q       (irq_o),
        .running_q   (running),
        .restart_o   (restart)
    );

endmodule

// File: tb/proc_ctr_timer_test.sv
module proc_ctr_timer_test;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        user_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_edge = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    proc_ctr_timer #(
        .TICK_DIV (DIV)
    ) uut (
        .clk         (clk),
        .rst         (rst),
        .user_mode_i (user_mode),
        .req_valid_i (req_valid),
        .req_write_i (req_write),
        .req_addr_i  (req_addr),
        .req_wdata_i (req_wdata),
        .rd_valid_o  (rd_valid),
        .rd_data_o   (rd_data),
        .irq_o       (irq)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops the expected read results as the design returns them
    always @(negedge clk) begin : monitor
        logic [31:0] e;
        string       t;
        if (!rst && rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R12 unexpected read actual=%h expected=none", rd_data);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", t, rd_data, e);
                end
            end
        end
    end

    function automatic logic [31:0] word(input int n);
        return 32'(n) << 9;
    endfunction

    // expected step count before edge e, for a clear at edge c
    function automatic int steps(input int e, input int c);
        return (e - 1 - c) / DIV;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called right after a falling edge; the access lands on the next rising edge
    task automatic bus(input bit wr, input int off, input logic [31:0] d);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = 5'(off << 2);
        req_wdata = d;
        last_edge = cyc + 1;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        req_wdata = '0;
    endtask

    task automatic rd(input int off, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus(1'b0, off, '0);
    endtask

    task automatic wr(input int off, input logic [31:0] d);
        bus(1'b1, off, d);
    endtask

    // make the next access land on edge e
    task automatic wait_to(input int e);
        while (cyc + 1 < e) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : driver
        int e0, e1, e2, e3, eu, es, ek, ew, ew2, el, frozen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        e0 = cyc;
        chk("R1 irq after reset", 32'(irq), 32'd0);
        chk("R12 no read valid after reset", 32'(rd_valid), 32'd0);
        rd(0, 32'h7FFF_FE00, "R1 limit at reset");
        rd(1, word(steps(last_edge + 1, e0)), "R1 count at reset");

        // limit mode, limit 5, junk in bit 31 and bits 8..0
        wr(0, 32'h8000_0BFF);
        e0 = last_edge;
        chk("R3 irq low after limit write", 32'(irq), 32'd0);
        wait_to(e0 + 13);
        rd(1, word(3), "R2 count after three steps");
        wait_to(e0 + 20);
        chk("R6 irq before limit", 32'(irq), 32'd0);
        wait_to(e0 + 21);
        chk("R6 irq on limit", 32'(irq), 32'd1);
        wait_to(e0 + 29);
        rd(1, 32'h8000_0000 | word(7 % 5), "R6 wrap with reached flag");
        rd(0, 32'h0000_0A00, "R7 limit read masks bits");
        chk("R7 limit read drops irq", 32'(irq), 32'd0);
        rd(1, word(steps(last_edge + 1, e0) % 5), "R7 reached cleared by limit read");

        // offset 2 keeps the count
        wr(0, word(5));
        e1 = last_edge;
        wait_to(e1 + 14);
        wr(2, word(20));
        wait_to(e1 + 29);
        rd(1, word(7), "R4 limit write keeps count");
        chk("R4 no irq under new limit", 32'(irq), 32'd0);

        // zero limit and unused offsets
        wr(2, 32'h0000_0000);
        rd(0, 32'h7FFF_FE00, "R5 zero limit becomes maximum");
        wr(5, 32'h0000_0400);
        rd(0, 32'h7FFF_FE00, "R11 write to offset 5 ignored");
        rd(6, 32'h0, "R11 offset 6 reads zero");
        rd(3, 32'h0, "R11 offset 3 reads zero in limit mode");

        // limit 2, then a clearing write keeps the flag
        wr(0, word(2));
        e2 = last_edge;
        wait_to(e2 + 8);
        chk("R6 irq low one cycle early", 32'(irq), 32'd0);
        wait_to(e2 + 9);
        chk("R6 irq raised at limit 2", 32'(irq), 32'd1);
        wait_to(e2 + 10);
        wr(0, word(2));
        e3 = last_edge;
        chk("R3 limit write drops irq", 32'(irq), 32'd0);
        rd(1, 32'h8000_0000, "R3 reached kept by limit write");
        wait_to(e3 + 9);
        chk("R6 irq raised again", 32'(irq), 32'd1);

        // enter user mode with irq pending
        wait_to(e3 + 10);
        user_mode = 1'b1;
        eu = cyc + 1;
        @(negedge clk);
        chk("R10 mode change drops irq", 32'(irq), 32'd0);
        rd(3, 32'h1, "R9 running after mode change");
        rd(0, 32'h0, "R8 upper word");
        wait_to(eu + 25);
        rd(1, word(6), "R8 lower word after six steps");
        wait_to(eu + 150);
        chk("R9 no irq in user mode", 32'(irq), 32'd0);
        wait_to(eu + 201);
        rd(1, word(50), "R8 lower word after fifty steps");
        wait_to(eu + 203);
        wr(3, 32'hFFFF_FFFE);
        es = last_edge;
        frozen = (es - eu) / DIV;
        rd(3, 32'h0, "R9 stopped state");
        wait_to(eu + 300);
        rd(1, word(frozen), "R9 count frozen while stopped");
        wait_to(eu + 302);
        wr(3, 32'h0000_0001);
        ek = last_edge;
        wait_to(eu + 321);
        rd(1, word(frozen + steps(eu + 321, eu) - (ek - eu) / DIV), "R9 count resumes after start");
        wr(2, word(9));
        rd(2, 32'h0, "R11 offset 2 reads zero in user mode");

        wr(1, 32'hDEAD_BEEF);
        ew = last_edge;
        wait_to(ew + 13);
        rd(1, word(3), "R8 lower-word write resets count");
        wait_to(ew + 20);
        wr(0, 32'h1234_5678);
        ew2 = last_edge;
        rd(1, word(steps(last_edge + 1, ew2)), "R8 upper-word write resets count");
        chk("R9 irq low after user writes", 32'(irq), 32'd0);

        // stop, then leave user mode: running must be restored
        wr(3, 32'h0);
        wait_to(last_edge + 5);
        user_mode = 1'b0;
        el = cyc + 1;
        @(negedge clk);
        wait_to(el + 5);
        rd(1, word(1), "R10 return to limit mode clears and runs");
        rd(3, 32'h0, "R11 offset 3 unused in limit mode");
        rd(0, word(2), "R11 user-mode offset 2 write left limit");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R12 missing reads actual=%0d expected=0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule